// File: doc/BRIEF.md
# Cascadable Vectored Interrupt Controller

This block collects eight interrupt request lines and presents a single interrupt line to a processor. A rising edge on a request line latches a pending bit. The bit stays pending only while its line remains high, and it can be masked. An unmasked pending request raises the interrupt output.

The processor answers with two low pulses on an acknowledge line. On the first pulse the controller picks the winning request under fixed priority, with line 0 highest. It clears that request's pending bit and marks the request as in service. On the second pulse it drives an 8-bit vector onto the data bus. The vector is a programmable 5-bit base with the 3-bit winner number below it.

Several controllers can be chained. A master drives the winner's number on a 3-bit cascade bus when that input has a slave attached, and in that case leaves the data bus to the slave. A slave drives the data bus only when the cascade bus carries its own identity. A non-specific end-of-interrupt strobe retires the highest-priority in-service entry.

Top module: `vint_ctrl`

## Requirements
- R1: A rising edge on `irq_in[i]` makes request i pending from the next clock. A pending request that drops its line before the first acknowledge stops being pending.
- R2: `int_out` is high exactly when some pending request is unmasked and ranks strictly above every in-service entry.
- R3: Priority is fixed: a lower line number always beats a higher one.
- R4: At the first falling edge of `ack_n` the winner's pending bit is cleared and its in-service bit is set. While it is set, requests of equal or lower priority cannot raise `int_out`, and higher ones still can.
- R5: A one-cycle `eoi_we` clears the lowest-numbered in-service bit.
- R6: In master mode, when bit w of the link map is set for winner w, `cas_out` carries w with `cas_oe` high. This runs from the clock after the first acknowledge falls until the clock after the second acknowledge rises.
- R7: During the second acknowledge pulse, `dout` = {base[4:0], winner[2:0]} with `dout_oe` high. A master drives it only when the winner's link-map bit is clear. The base used is the one held at the first acknowledge.
- R8: In slave mode the identity is `link_data[2:0]` as last written. The slave drives `dout` only while `cas_in` equals that identity, and it never raises `cas_oe`.
- R9: If nothing is eligible at the first acknowledge, the vector uses winner 7 and no in-service bit is set.
- R10: Writing `mask_data` with bit i set keeps request i pending but unable to raise `int_out`. Clearing the bit lets the request raise it again.
- R11: After reset, `int_out`, `cas_oe` and `dout_oe` are low, and the mask, base and link map are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Request lines, edge latched |
| ack_n | input | 1 | Active-low acknowledge from the processor |
| mask_we | input | 1 | Mask register write strobe |
| mask_data | input | 8 | Mask value, 1 = masked |
| base_we | input | 1 | Vector base write strobe |
| base_data | input | 5 | Upper five vector bits |
| link_we | input | 1 | Link map / slave identity write strobe |
| link_data | input | 8 | Master: inputs with slaves; slave: identity in [2:0] |
| eoi_we | input | 1 | Non-specific end-of-interrupt strobe |
| is_master | input | 1 | Strap: 1 = master, 0 = slave |
| cas_in | input | 3 | Cascade bus as seen by a slave |
| cas_out | output | 3 | Cascade bus driven by a master |
| cas_oe | output | 1 | Cascade drive enable |
| int_out | output | 1 | Interrupt request to the processor |
| dout | output | 8 | Vector output |
| dout_oe | output | 1 | Vector drive enable |

## Verification
Pending bits, mask and in-service state register on a clock edge, and `int_out` follows them combinationally, so a request edge shows on `int_out` one clock after it is sampled. Cascade and data enables come from the handshake phase register, so each one changes one clock after the acknowledge edge that moves the phase. `dout_oe` in slave mode also follows `cas_in` within the same cycle. A behavioural model in the bench advances on the same clock edge. All outputs are compared a few nanoseconds after every rising edge, once the registers have settled and well before inputs next move at the falling edge.

// File: rtl/vint_pkg.sv
package vint_pkg;
  // Handshake phase of the two-pulse acknowledge
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_GAP    = 2'd2,
    PH_SECOND = 2'd3
  } hs_phase_e;
endpackage

// File: rtl/vint_req_latch.sv
module vint_req_latch #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic [N_IN-1:0] clr_vec,
  output logic [N_IN-1:0] irr_o
);
  logic [N_IN-1:0] irq_q, irr_q, irr_d, rise;

  always_comb begin
    rise  = irq_in & ~irq_q;
    // pending only while the line stays high; granted bit is retired
    irr_d = ((irr_q | rise) & irq_in) & ~clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr_q <= '0;
    end else begin
      irq_q <= irq_in;
      irr_q <= irr_d;
    end
  end

  assign irr_o = irr_q;

  // R1
  req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q & ~$past(irq_in)) == '0);
endmodule

// File: rtl/vint_isr.sv
module vint_isr #(
  parameter int unsigned N_IN = 8,
  parameter int unsigned IDW  = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [IDW-1:0]  set_idx,
  input  logic            eoi,
  output logic [N_IN-1:0] isr_o,
  output logic [N_IN-1:0] blk_o
);
  logic [N_IN-1:0] isr_q, isr_d, low_bit, set_vec;

  always_comb begin
    low_bit = isr_q & (~isr_q + 1'b1);
    set_vec = set_en ? ({{(N_IN-1){1'b0}}, 1'b1} << set_idx) : '0;
    isr_d   = (isr_q & ~(eoi ? low_bit : '0)) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  // blocking mask: bit j blocked if any in-service bit at j or above in rank
  assign blk_o[0] = isr_q[0];
  for (genvar j = 1; j < N_IN; j++) begin : g_blk
    assign blk_o[j] = blk_o[j-1] | isr_q[j];
  end

  assign isr_o = isr_q;

  // R4
  isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> isr_q[$past(set_idx)]);

  // R5
  eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (isr_q != '0) && !set_en) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

// File: rtl/vint_resolve.sv
module vint_resolve #(
  parameter int unsigned N_IN = 8,
  parameter int unsigned IDW  = $clog2(N_IN)
) (
  input  logic [N_IN-1:0] irr,
  input  logic [N_IN-1:0] imr,
  input  logic [N_IN-1:0] blk,
  output logic            any,
  output logic [IDW-1:0]  idx
);
  logic [N_IN-1:0] elig;

  always_comb begin
    elig = irr & ~imr & ~blk;
    any  = 1'b0;
    idx  = '0;
    // scan downward so the lowest eligible number wins
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any = 1'b1;
        idx = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/vint_handshake.sv
module vint_handshake
  import vint_pkg::*;
#(
  parameter int unsigned N_IN = 8,
  parameter int unsigned IDW  = $clog2(N_IN),
  parameter int unsigned VW   = 8,
  localparam int unsigned BW  = VW - IDW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_n,
  input  logic            is_master,
  input  logic [N_IN-1:0] link,
  input  logic [IDW-1:0]  cas_in,
  input  logic            any,
  input  logic [IDW-1:0]  idx,
  input  logic [BW-1:0]   base,
  output logic            grant,
  output logic [IDW-1:0]  cas_out,
  output logic            cas_oe,
  output logic [VW-1:0]   dout,
  output logic            dout_oe
);
  hs_phase_e      ph_q, ph_d;
  logic           ack_q, ack_fall, ack_rise, take;
  logic [IDW-1:0] win_q, win_d;
  logic [VW-1:0]  vec_q, vec_d;
  logic           routed;

  always_comb begin
    ack_fall = ack_q & ~ack_n;
    ack_rise = ~ack_q & ack_n;
    take     = (ph_q == PH_IDLE) && ack_fall;
    grant    = take && any;
    win_d    = win_q;
    vec_d    = vec_q;
    ph_d     = ph_q;
    if (take) begin
      win_d = any ? idx : {IDW{1'b1}};
      vec_d = {base, win_d};
    end
    unique case (ph_q)
      PH_IDLE:   if (ack_fall) ph_d = PH_FIRST;
      PH_FIRST:  if (ack_rise) ph_d = PH_GAP;
      PH_GAP:    if (ack_fall) ph_d = PH_SECOND;
      PH_SECOND: if (ack_rise) ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      ack_q <= 1'b1;
      win_q <= '0;
      vec_q <= '0;
    end else begin
      ph_q  <= ph_d;
      ack_q <= ack_n;
      if (take) begin
        win_q <= win_d;
        vec_q <= vec_d;
      end
    end
  end

  always_comb begin
    routed  = link[win_q];
    cas_out = win_q;
    cas_oe  = is_master && (ph_q != PH_IDLE) && routed;
    dout    = vec_q;
    dout_oe = (ph_q == PH_SECOND) &&
              (is_master ? !routed : (cas_in == link[IDW-1:0]));
  end

  // R6
  cas_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_oe |-> is_master);

  // R7
  data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !ack_q);

  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe)) |-> $stable(dout));
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl #(
  parameter int unsigned N_IN = 8,
  parameter int unsigned VW   = 8,
  localparam int unsigned IDW = $clog2(N_IN),
  localparam int unsigned BW  = VW - IDW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic            ack_n,
  input  logic            mask_we,
  input  logic [N_IN-1:0] mask_data,
  input  logic            base_we,
  input  logic [BW-1:0]   base_data,
  input  logic            link_we,
  input  logic [N_IN-1:0] link_data,
  input  logic            eoi_we,
  input  logic            is_master,
  input  logic [IDW-1:0]  cas_in,
  output logic [IDW-1:0]  cas_out,
  output logic            cas_oe,
  output logic            int_out,
  output logic [VW-1:0]   dout,
  output logic            dout_oe
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // configuration registers
  logic [N_IN-1:0] imr_q, imr_d, link_q, link_d;
  logic [BW-1:0]   base_q, base_d;

  always_comb begin
    imr_d  = mask_we ? mask_data : imr_q;
    base_d = base_we ? base_data : base_q;
    link_d = link_we ? link_data : link_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      imr_q  <= '0;
      base_q <= '0;
      link_q <= '0;
    end else begin
      imr_q  <= imr_d;
      base_q <= base_d;
      link_q <= link_d;
    end
  end

  logic [N_IN-1:0] irr, isr, blk, clr_vec;
  logic            any, grant;
  logic [IDW-1:0]  idx;

  assign clr_vec = grant ? ({{(N_IN-1){1'b0}}, 1'b1} << idx) : '0;

  vint_req_latch #(.N_IN(N_IN)) u_req (
    .clk(clk), .rst_n(rst_i), .irq_in(irq_in), .clr_vec(clr_vec), .irr_o(irr)
  );

  vint_isr #(.N_IN(N_IN), .IDW(IDW)) u_isr (
    .clk(clk), .rst_n(rst_i), .set_en(grant), .set_idx(idx), .eoi(eoi_we),
    .isr_o(isr), .blk_o(blk)
  );

  vint_resolve #(.N_IN(N_IN), .IDW(IDW)) u_res (
    .irr(irr), .imr(imr_q), .blk(blk), .any(any), .idx(idx)
  );

  vint_handshake #(.N_IN(N_IN), .IDW(IDW), .VW(VW)) u_hs (
    .clk(clk), .rst_n(rst_i), .ack_n(ack_n), .is_master(is_master),
    .link(link_q), .cas_in(cas_in), .any(any), .idx(idx), .base(base_q),
    .grant(grant), .cas_out(cas_out), .cas_oe(cas_oe),
    .dout(dout), .dout_oe(dout_oe)
  );

  assign int_out = any;

  // R2
  int_src_chk: assert property (@(posedge clk) disable iff (!rst_i)
    int_out |-> ((irr & ~imr_q) != '0));

  // R4
  int_blk_chk: assert property (@(posedge clk) disable iff (!rst_i)
    int_out |-> ((irr & ~imr_q & ~blk) != '0));

  // R10
  mask_apply_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (mask_we && (mask_data == '1)) |=> !int_out);
endmodule

// File: tb/vint_ctrl_bench.sv
module vint_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n, ack_n, mask_we, base_we, link_we, eoi_we, is_master;
  logic [7:0] irq_in, mask_data, link_data;
  logic [4:0] base_data;
  logic [2:0] cas_in, cas_out;
  logic       cas_oe, int_out, dout_oe;
  logic [7:0] dout;

  always #4 clk = ~clk;

  vint_ctrl u_vint_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_n(ack_n),
    .mask_we(mask_we), .mask_data(mask_data), .base_we(base_we),
    .base_data(base_data), .link_we(link_we), .link_data(link_data),
    .eoi_we(eoi_we), .is_master(is_master), .cas_in(cas_in),
    .cas_out(cas_out), .cas_oe(cas_oe), .int_out(int_out),
    .dout(dout), .dout_oe(dout_oe)
  );

  int    n_chk = 0, n_bad = 0;
  string tag = "R11";
  bit    cmp_en = 1'b0;
  int    last_vec = -1, last_cas = -1;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_irqq, m_irr, m_isr, m_imr, m_link;
  logic [4:0] m_base;
  logic       m_ackq;
  int         m_ph, rel;
  int         m_win, m_vec;

  function automatic logic [7:0] eligible();
    logic [7:0] e;
    bit b = 0;
    for (int i = 0; i < 8; i++) begin
      b    = b | m_isr[i];
      e[i] = m_irr[i] & ~m_imr[i] & ~b;
    end
    return e;
  endfunction

  task automatic model_step();
    logic [7:0] nirr, nisr, e;
    int  w = -1;
    bit  fall, rs, done = 0;
    nirr = (m_irr | (irq_in & ~m_irqq)) & irq_in;
    nisr = m_isr;
    e    = eligible();
    for (int i = 7; i >= 0; i--) if (e[i]) w = i;
    if (eoi_we)
      for (int i = 0; i < 8; i++)
        if (!done && m_isr[i]) begin nisr[i] = 0; done = 1; end
    fall = m_ackq && !ack_n;
    rs   = !m_ackq && ack_n;
    case (m_ph)
      0: if (fall) begin
           m_ph = 1;
           if (w >= 0) begin m_win = w; nirr[w] = 0; nisr[w] = 1; end
           else m_win = 7;
           m_vec = m_base * 8 + m_win;
         end
      1: if (rs) m_ph = 2;
      2: if (fall) m_ph = 3;
      default: if (rs) m_ph = 0;
    endcase
    m_irqq = irq_in; m_ackq = ack_n; m_irr = nirr; m_isr = nisr;
    if (mask_we) m_imr = mask_data;
    if (base_we) m_base = base_data;
    if (link_we) m_link = link_data;
  endtask

  always @(posedge clk) begin
    if (!rst_n) rel = 0;
    if (rel < 2) begin
      m_irqq = 0; m_irr = 0; m_isr = 0; m_imr = 0; m_link = 0; m_base = 0;
      m_ackq = 1; m_ph = 0; m_win = 0; m_vec = 0;
      if (rst_n) rel++;
    end else model_step();
    #3;
    if (cmp_en) begin
      bit ei, ec, ed;
      ei = eligible() != 0;
      ec = is_master && m_ph != 0 && m_link[m_win];
      ed = m_ph == 3 && (is_master ? !m_link[m_win] : cas_in == m_link[2:0]);
      chk("int_out", int_out, ei);
      chk("cas_oe", cas_oe, ec);
      chk("dout_oe", dout_oe, ed);
      if (ec) chk("cas_out", cas_out, m_win);
      if (ed) chk("dout", dout, m_vec);
      if (dout_oe) last_vec = dout;
      if (cas_oe) last_cas = cas_out;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_seq();
    last_vec = -1; last_cas = -1;
    ack_n = 0; tick(2); ack_n = 1; tick(2);
    ack_n = 0; tick(2); ack_n = 1; tick(2);
  endtask

  task automatic eoi();
    eoi_we = 1; tick(1); eoi_we = 0; tick(1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; ack_n = 1; mask_we = 0; base_we = 0; link_we = 0; eoi_we = 0;
    is_master = 1; irq_in = 0; mask_data = 0; link_data = 0; base_data = 0;
    cas_in = 0;
    tick(1); cmp_en = 1; tick(2);
    rst_n = 1; tick(4);
    tag = "R11";
    chk("int_out", int_out, 0); chk("cas_oe", cas_oe, 0); chk("dout_oe", dout_oe, 0);

    base_data = 5'h15; base_we = 1; tick(1); base_we = 0;
    // R1: edge latches, drop clears
    tag = "R1";
    irq_in[3] = 1; tick(2); chk("int_out", int_out, 1);
    irq_in[3] = 0; tick(2); chk("int_out", int_out, 0);
    // R10: masking
    tag = "R10";
    mask_data = 8'h08; mask_we = 1; tick(1); mask_we = 0;
    irq_in[3] = 1; tick(2); chk("int_out", int_out, 0);
    mask_data = 8'h00; mask_we = 1; tick(1); mask_we = 0; tick(1);
    chk("int_out", int_out, 1);
    irq_in[3] = 0; tick(2);
    // R3 / R7: priority and vector
    tag = "R3";
    irq_in[5] = 1; irq_in[2] = 1; tick(2);
    ack_seq(); chk("vector", last_vec, 32'hAA);
    // R4: in-service blocks lower, admits higher
    tag = "R4";
    chk("int_out", int_out, 0);
    irq_in[1] = 1; tick(2); chk("int_out", int_out, 1);
    ack_seq(); chk("vector", last_vec, 32'hA9);
    // R5: end of interrupt
    tag = "R5";
    eoi(); chk("int_out", int_out, 0);
    eoi(); chk("int_out", int_out, 1);
    tag = "R7";
    ack_seq(); chk("vector", last_vec, 32'hAD);
    eoi(); irq_in = 0; tick(2);
    // R6: cascade routing
    tag = "R6";
    link_data = 8'h02; link_we = 1; tick(1); link_we = 0;
    irq_in[1] = 1; tick(2);
    ack_seq(); chk("cas_out", last_cas, 1); chk("vector", last_vec, 32'hFFFFFFFF);
    eoi(); irq_in = 0;
    link_data = 8'h00; link_we = 1; tick(1); link_we = 0; tick(1);
    // R9: spurious
    tag = "R9";
    irq_in[6] = 1; tick(2); irq_in[6] = 0; tick(2);
    ack_seq(); chk("vector", last_vec, 32'hAF);
    irq_in[7] = 1; tick(2); chk("int_out", int_out, 1);
    ack_seq(); chk("vector", last_vec, 32'hAF);
    eoi(); irq_in = 0; tick(2);
    // R8: slave mode
    tag = "R8";
    rst_n = 0; is_master = 0; tick(2); rst_n = 1; tick(4);
    link_data = 8'h04; link_we = 1; base_data = 5'h03; base_we = 1; tick(1);
    link_we = 0; base_we = 0;
    irq_in[0] = 1; cas_in = 3'd4; tick(2);
    ack_seq(); chk("vector", last_vec, 32'h18);
    eoi(); irq_in[0] = 0; tick(2); irq_in[0] = 1; cas_in = 3'd3; tick(2);
    ack_seq(); chk("vector", last_vec, 32'hFFFFFFFF);
    eoi(); tick(4);
    summary();
    $finish;
  end
endmodule